// File: doc/BRIEF.md
# UART Register Bank with Interrupt Prioritizer

This block is the processor-facing register set of a single-channel asynchronous serial controller. A 3-bit address with read and write strobes selects one of eight byte locations. Behind them sit the received byte, the byte to send, the interrupt enables, the interrupt identification, the line and modem control bytes, the line and modem status bytes, and a scratch byte. The top bit of the line control byte is a bank switch. When it is set, addresses 0 and 1 reach the low and high halves of the 16-bit baud divisor in place of the data and enable registers.

The shifters, FIFOs and baud timing live elsewhere. They reach this block as event inputs: a received byte with its error tags, the shifter taking the held byte, and the shifter going idle. They also reach it as four modem status lines. The block merges its four interrupt sources: line error, received data, holding register empty, and modem change. Each source is masked by its enable bit. The block reports the most urgent enabled source through the identification register and through `irq_o`. Reads of the status and identification registers carry clearing side effects. Reads are combinational from `addr_i` while `rd_i` is high, and their side effects take place at the clock edge that ends the read cycle.

Top module: `sio_regbank`

## Requirements
- R1: After reset the eight addresses read 0x00, 0x00, 0x01, 0x00, 0x00, 0x60, 0x00 and 0x00 (modem lines low, shifter idle), `divisor_o` is 0 and `irq_o` is low.
- R2: Bit 7 of the line control byte (address 3) is the bank switch. While it is 1, addresses 0 and 1 read and write the divisor low and high bytes (`divisor_o` = {high, low}), and no transmit load occurs. While it is 0, a write to address 0 drives `tx_data_o` and pulses `tx_load_o` high for the single cycle after the write edge.
- R3: `rx_valid_i` stores `rx_data_i` and sets data-ready (line status bit 0). A read of address 0 with the bank switch at 0 returns the byte and clears data-ready.
- R4: Line status bits 2, 3 and 4 (parity, framing, break) latch from the tags sent with each byte. Bit 1 (overrun) sets when a byte arrives while data-ready is still set. A read of address 5 clears bits 4:1 and leaves data-ready as it was.
- R5: Line status bit 5 (holding empty) clears on a transmit write and sets on `tx_taken_i`. Bit 6 is bit 5 AND `tsr_idle_i`.
- R6: Modem status (address 6) bits 4..7 show CTS, DSR, RI and DCD. Bits 0, 1 and 3 latch any change of CTS, DSR and DCD. Bit 2 latches a 1-to-0 change of RI. A read of address 6 clears bits 3:0.
- R7: Bit 4 of modem control (address 4) is loopback. In loopback, RTS, DTR, OUT1 and OUT2 (modem control bits 1, 0, 2, 3) feed CTS, DSR, RI and DCD, and all four modem outputs are held low. Modem control reads back only bits 4:0.
- R8: Interrupt enable (address 1) keeps bits 3:0: received data (0), holding empty (1), line error (2) and modem change (3). Identification bit 0 is 0 when an enabled cause is pending. Bits 2:1 then read 11 for line error, 10 for received data, 01 for holding empty and 00 for modem change. With nothing pending the register reads 0x01.
- R9: When several enabled causes are pending, identification shows the highest in the order line error, received data, holding empty, modem change.
- R10: The holding-empty cause rises when the holding register becomes empty, or when its enable goes 0 to 1 while the register is empty. It clears on a transmit write, or on a read of address 2 that shows it.
- R11: `irq_o` is high exactly when an enabled cause is pending and modem control bit 3 (OUT2) is set.
- R12: Address 7 stores and returns any byte without side effects.
- R13: Writes to addresses 2, 5 and 6 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, zero when `rd_i` is low |
| rx_valid_i | input | 1 | Received byte event |
| rx_data_i | input | 8 | Received byte |
| rx_parity_err_i | input | 1 | Parity error tag for the byte |
| rx_frame_err_i | input | 1 | Framing error tag for the byte |
| rx_break_i | input | 1 | Break tag for the byte |
| tx_load_o | output | 1 | One-cycle pulse after a transmit write |
| tx_data_o | output | 8 | Held transmit byte |
| tx_taken_i | input | 1 | Shifter took the held byte |
| tsr_idle_i | input | 1 | Shifter idle |
| cts_i | input | 1 | Clear-to-send line |
| dsr_i | input | 1 | Data-set-ready line |
| ri_i | input | 1 | Ring indicator line |
| dcd_i | input | 1 | Carrier detect line |
| dtr_o | output | 1 | Data-terminal-ready output |
| rts_o | output | 1 | Request-to-send output |
| out1_o | output | 1 | User output 1 |
| out2_o | output | 1 | User output 2 |
| line_cfg_o | output | 7 | Line control bits 6:0 for the shifters |
| divisor_o | output | 16 | Baud divisor |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 8-bit data width, which makes a full sweep affordable. It covers all 256 scratch values and all 16 × 16 pairings of pending-cause set and enable mask. In each pairing the bench predicts the identification byte and `irq_o` from a priority encoder of its own. It then reads identification a second time to confirm that only a shown holding-empty cause is cleared. Directed sequences cover bank switching, overrun, clearing reads, the falling-edge rule for RI, and the loopback routing.

// File: rtl/sio_regbank_pkg.sv
package sio_regbank_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned N_SRC  = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA  = 3'd0,
    A_IEN   = 3'd1,
    A_IID   = 3'd2,
    A_LCTL  = 3'd3,
    A_MCTL  = 3'd4,
    A_LSTAT = 3'd5,
    A_MSTAT = 3'd6,
    A_SCR   = 3'd7
  } addr_e;

  typedef struct packed {
    logic wr_thr;
    logic wr_dll;
    logic wr_dlm;
    logic wr_ier;
    logic wr_lcr;
    logic wr_mcr;
    logic wr_scr;
    logic rd_rbr;
    logic rd_iir;
    logic rd_lsr;
    logic rd_msr;
  } strobe_t;
endpackage

// File: rtl/sio_reg_decode.sv
module sio_reg_decode
  import sio_regbank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dlab_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output strobe_t           stb_o
);
  always_comb begin
    stb_o = '0;
    case (addr_i)
      A_DATA: begin
        if (dlab_i) stb_o.wr_dll = wr_i;
        else begin
          stb_o.wr_thr = wr_i;
          stb_o.rd_rbr = rd_i;
        end
      end
      A_IEN: begin
        if (dlab_i) stb_o.wr_dlm = wr_i;
        else        stb_o.wr_ier = wr_i;
      end
      A_IID:   stb_o.rd_iir = rd_i;
      A_LCTL:  stb_o.wr_lcr = wr_i;
      A_MCTL:  stb_o.wr_mcr = wr_i;
      A_LSTAT: stb_o.rd_lsr = rd_i;
      A_MSTAT: stb_o.rd_msr = rd_i;
      A_SCR:   stb_o.wr_scr = wr_i;
      default: stb_o = '0;
    endcase
  end
endmodule

// File: rtl/sio_modem_track.sv
// lines_i order: [0] cts, [1] dsr, [2] ri, [3] dcd
module sio_modem_track (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] lines_i,
  input  logic       clr_i,
  output logic [7:0] msr_o
);
  logic [3:0] prev_q, delta_q, delta_set;

  always_comb begin
    delta_set    = lines_i ^ prev_q;
    delta_set[2] = prev_q[2] & ~lines_i[2]; // RI trailing edge only
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      delta_q <= '0;
    end else begin
      prev_q  <= lines_i;
      delta_q <= (clr_i ? 4'b0 : delta_q) | delta_set;
    end
  end

  assign msr_o = {lines_i, delta_q};
endmodule

// File: rtl/sio_irq_rank.sv
// req_i[0] is most urgent; cause code = N_SRC-1-index
module sio_irq_rank
  import sio_regbank_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [N_SRC-1:0] req_i,
  output logic [DW-1:0]    iir_o,
  output logic             any_o,
  output logic [N_SRC-1:0] grant_o
);
  localparam int unsigned ID_W = $clog2(N_SRC);

  logic [ID_W-1:0] id;

  for (genvar i = 0; i < N_SRC; i++) begin : g_pri
    if (i == 0) begin : g_top
      assign grant_o[i] = req_i[i];
    end else begin : g_low
      assign grant_o[i] = req_i[i] & ~|req_i[i-1:0];
    end
  end

  always_comb begin
    id = '0;
    for (int i = 0; i < N_SRC; i++)
      if (grant_o[i]) id = ID_W'(N_SRC - 1 - i);
  end

  assign any_o = |req_i;
  assign iir_o = DW'({id, ~any_o});
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
  import sio_regbank_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              rx_valid_i,
  input  logic [DW-1:0]     rx_data_i,
  input  logic              rx_parity_err_i,
  input  logic              rx_frame_err_i,
  input  logic              rx_break_i,
  output logic              tx_load_o,
  output logic [DW-1:0]     tx_data_o,
  input  logic              tx_taken_i,
  input  logic              tsr_idle_i,
  input  logic              cts_i,
  input  logic              dsr_i,
  input  logic              ri_i,
  input  logic              dcd_i,
  output logic              dtr_o,
  output logic              rts_o,
  output logic              out1_o,
  output logic              out2_o,
  output logic [DW-2:0]     line_cfg_o,
  output logic [2*DW-1:0]   divisor_o,
  output logic              irq_o
);
  localparam int unsigned IER_W = N_SRC;
  localparam int unsigned MCR_W = 5;

  strobe_t          stb;
  logic [DW-1:0]    rbr_q, thr_q, lcr_q, scr_q, dll_q, dlm_q;
  logic [IER_W-1:0] ier_q;
  logic [MCR_W-1:0] mcr_q;
  logic             dr_q, oe_q, pe_q, fe_q, bi_q;
  logic             thre_q, thre_pend_q, tx_load_q;
  logic             dlab, loop, temt, line_err, any_irq;
  logic             pend_set, pend_clr;
  logic [3:0]       lines;
  logic [7:0]       msr;
  logic [DW-1:0]    lsr, iir, rmux;
  logic [N_SRC-1:0] req, grant;

  assign dlab = lcr_q[DW-1];
  assign loop = mcr_q[4];

  sio_reg_decode u_dec (
    .addr_i (addr_i),
    .dlab_i (dlab),
    .wr_i   (wr_i),
    .rd_i   (rd_i),
    .stb_o  (stb)
  );

  // plain control registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q     <= '0;
      mcr_q     <= '0;
      ier_q     <= '0;
      scr_q     <= '0;
      dll_q     <= '0;
      dlm_q     <= '0;
      thr_q     <= '0;
      tx_load_q <= 1'b0;
    end else begin
      tx_load_q <= stb.wr_thr;
      if (stb.wr_lcr) lcr_q <= wdata_i;
      if (stb.wr_mcr) mcr_q <= wdata_i[MCR_W-1:0];
      if (stb.wr_ier) ier_q <= wdata_i[IER_W-1:0];
      if (stb.wr_scr) scr_q <= wdata_i;
      if (stb.wr_dll) dll_q <= wdata_i;
      if (stb.wr_dlm) dlm_q <= wdata_i;
      if (stb.wr_thr) thr_q <= wdata_i;
    end
  end

  // receive side: data-ready and error tags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbr_q <= '0;
      dr_q  <= 1'b0;
      oe_q  <= 1'b0;
      pe_q  <= 1'b0;
      fe_q  <= 1'b0;
      bi_q  <= 1'b0;
    end else begin
      if (rx_valid_i) rbr_q <= rx_data_i;
      if (rx_valid_i)      dr_q <= 1'b1;
      else if (stb.rd_rbr) dr_q <= 1'b0;
      oe_q <= (oe_q & ~stb.rd_lsr) | (rx_valid_i & dr_q & ~stb.rd_rbr);
      pe_q <= (pe_q & ~stb.rd_lsr) | (rx_valid_i & rx_parity_err_i);
      fe_q <= (fe_q & ~stb.rd_lsr) | (rx_valid_i & rx_frame_err_i);
      bi_q <= (bi_q & ~stb.rd_lsr) | (rx_valid_i & rx_break_i);
    end
  end

  // transmit side: holding empty and its interrupt cause
  assign pend_set = (tx_taken_i & ~thre_q & ~stb.wr_thr)
                  | (stb.wr_ier & wdata_i[1] & ~ier_q[1] & thre_q);
  assign pend_clr = stb.wr_thr | (stb.rd_iir & grant[2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thre_q      <= 1'b1;
      thre_pend_q <= 1'b0;
    end else begin
      if (stb.wr_thr)      thre_q <= 1'b0;
      else if (tx_taken_i) thre_q <= 1'b1;
      thre_pend_q <= pend_set | (thre_pend_q & ~pend_clr);
    end
  end

  assign temt = thre_q & tsr_idle_i;
  assign lsr  = DW'({temt, thre_q, bi_q, fe_q, pe_q, oe_q, dr_q});

  // modem status, with loopback routing
  assign lines = loop ? {mcr_q[3], mcr_q[2], mcr_q[0], mcr_q[1]}
                      : {dcd_i, ri_i, dsr_i, cts_i};

  sio_modem_track u_msr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lines_i (lines),
    .clr_i   (stb.rd_msr),
    .msr_o   (msr)
  );

  // interrupt causes, most urgent first
  assign line_err = oe_q | pe_q | fe_q | bi_q;
  assign req = {ier_q[3] & |msr[3:0],
                ier_q[1] & thre_pend_q,
                ier_q[0] & dr_q,
                ier_q[2] & line_err};

  sio_irq_rank #(.DW(DW)) u_rank (
    .req_i   (req),
    .iir_o   (iir),
    .any_o   (any_irq),
    .grant_o (grant)
  );

  always_comb begin
    case (addr_i)
      A_DATA:  rmux = dlab ? dll_q : rbr_q;
      A_IEN:   rmux = dlab ? dlm_q : DW'(ier_q);
      A_IID:   rmux = iir;
      A_LCTL:  rmux = lcr_q;
      A_MCTL:  rmux = DW'(mcr_q);
      A_LSTAT: rmux = lsr;
      A_MSTAT: rmux = DW'(msr);
      A_SCR:   rmux = scr_q;
      default: rmux = '0;
    endcase
  end

  assign rdata_o    = rd_i ? rmux : '0;
  assign tx_load_o  = tx_load_q;
  assign tx_data_o  = thr_q;
  assign dtr_o      = mcr_q[0] & ~loop;
  assign rts_o      = mcr_q[1] & ~loop;
  assign out1_o     = mcr_q[2] & ~loop;
  assign out2_o     = mcr_q[3] & ~loop;
  assign line_cfg_o = lcr_q[DW-2:0];
  assign divisor_o  = {dlm_q, dll_q};
  assign irq_o      = any_irq & mcr_q[3];
endmodule

// File: rtl/sio_regbank_chk.sv
module sio_regbank_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  addr_i,
  input logic        wr_i,
  input logic        rx_valid_i,
  input logic        tx_load_o,
  input logic [15:0] divisor_o,
  input logic        irq_o,
  input logic        dtr_o,
  input logic        rts_o,
  input logic        out1_o,
  input logic        out2_o,
  input logic        dlab,
  input logic [4:0]  mcr,
  input logic        dr,
  input logic        oe,
  input logic        rd_rbr,
  input logic        thre
);
  AST_TX_LOAD_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |-> $past(wr_i && addr_i == 3'd0 && !dlab)); // R2

  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && dlab && addr_i[2:1] == 2'b00) |=> $stable(divisor_o)); // R2

  AST_DR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> dr); // R3

  AST_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && dr && !rd_rbr |=> oe); // R4

  AST_THRE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 3'd0 && !dlab |=> !thre); // R5

  AST_LOOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcr[4] |-> !(dtr_o || rts_o || out1_o || out2_o)); // R7

  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> mcr[3]); // R11
endmodule

bind sio_regbank sio_regbank_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_i       (wr_i),
  .rx_valid_i (rx_valid_i),
  .tx_load_o  (tx_load_o),
  .divisor_o  (divisor_o),
  .irq_o      (irq_o),
  .dtr_o      (dtr_o),
  .rts_o      (rts_o),
  .out1_o     (out1_o),
  .out2_o     (out2_o),
  .dlab       (lcr_q[7]),
  .mcr        (mcr_q),
  .dr         (dr_q),
  .oe         (oe_q),
  .rd_rbr     (stb.rd_rbr),
  .thre       (thre_q)
);

// File: tb/sio_regbank_test.sv
module sio_regbank_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  addr = 0;
  logic        wr = 0, rd = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic        rx_valid = 0, pe = 0, fe = 0, bi = 0;
  logic [7:0]  rx_data = 0;
  logic        tx_load;
  logic [7:0]  tx_data;
  logic        tx_taken = 0, tsr_idle = 1;
  logic        cts = 0, dsr = 0, ri = 0, dcd = 0;
  logic        dtr, rts, out1, out2;
  logic [6:0]  line_cfg;
  logic [15:0] divisor;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sio_regbank uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_parity_err_i(pe), .rx_frame_err_i(fe), .rx_break_i(bi),
    .tx_load_o(tx_load), .tx_data_o(tx_data), .tx_taken_i(tx_taken),
    .tsr_idle_i(tsr_idle), .cts_i(cts), .dsr_i(dsr), .ri_i(ri), .dcd_i(dcd),
    .dtr_o(dtr), .rts_o(rts), .out1_o(out1), .out2_o(out2),
    .line_cfg_o(line_cfg), .divisor_o(divisor), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1;
    #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic rx_byte(input logic [7:0] d, input logic p, input logic f, input logic b);
    @(negedge clk); rx_data = d; pe = p; fe = f; bi = b; rx_valid = 1;
    @(negedge clk); rx_valid = 0; pe = 0; fe = 0; bi = 0;
  endtask

  task automatic tx_take();
    @(negedge clk); tx_taken = 1;
    @(negedge clk); tx_taken = 0;
  endtask

  function automatic logic [7:0] exp_iir(input logic [3:0] eff);
    if (eff[2])      return 8'h06;
    else if (eff[0]) return 8'h04;
    else if (eff[1]) return 8'h02;
    else if (eff[3]) return 8'h00;
    else             return 8'h01;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] rst_exp [8];
    rst_exp = '{8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h60, 8'h00, 8'h00};

    do_reset();
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd_reg(3'(a), d);
      chk($sformatf("R1 reset read addr %0d", a), d, rst_exp[a]);
    end
    chk("R1 divisor", divisor, 0);
    chk("R1 irq", irq, 0);

    // R12 scratch sweep
    for (int v = 0; v < 256; v++) begin
      wr_reg(3'd7, 8'(v));
      rd_reg(3'd7, d);
      chk("R12 scratch", d, v);
    end

    // R2 bank switch
    wr_reg(3'd3, 8'h80);
    wr_reg(3'd0, 8'h34);
    chk("R2 no load under bank switch", tx_load, 0);
    wr_reg(3'd1, 8'h12);
    chk("R2 divisor", divisor, 16'h1234);
    rd_reg(3'd0, d); chk("R2 read div low", d, 8'h34);
    rd_reg(3'd1, d); chk("R2 read div high", d, 8'h12);
    wr_reg(3'd3, 8'h03);
    rd_reg(3'd1, d); chk("R2 ier untouched", d, 8'h00);
    rd_reg(3'd3, d); chk("R2 lcr read", d, 8'h03);
    chk("R2 line cfg", line_cfg, 7'h03);
    wr_reg(3'd0, 8'hA5);
    chk("R2 tx load pulse", tx_load, 1);
    chk("R2 tx data", tx_data, 8'hA5);
    @(negedge clk);
    chk("R2 tx load single", tx_load, 0);
    chk("R2 divisor kept", divisor, 16'h1234);

    // R5 holding / shifter empty
    rd_reg(3'd5, d); chk("R5 lsr after write", d, 8'h00);
    tx_take();
    rd_reg(3'd5, d); chk("R5 lsr after take", d, 8'h60);
    tsr_idle = 0;
    rd_reg(3'd5, d); chk("R5 temt follows shifter", d, 8'h20);
    tsr_idle = 1;

    // R3 receive
    rx_byte(8'h5A, 0, 0, 0);
    rd_reg(3'd5, d); chk("R3 data ready", d, 8'h61);
    rd_reg(3'd0, d); chk("R3 rbr", d, 8'h5A);
    rd_reg(3'd5, d); chk("R3 dr cleared", d, 8'h60);

    // R4 errors and overrun
    rx_byte(8'h11, 1, 1, 1);
    rd_reg(3'd5, d); chk("R4 tags", d, 8'h7D);
    rx_byte(8'h22, 0, 0, 0);
    rd_reg(3'd5, d); chk("R4 tags cleared, overrun", d, 8'h63);
    rd_reg(3'd5, d); chk("R4 cleared by read", d, 8'h61);
    rd_reg(3'd0, d); chk("R4 latest byte", d, 8'h22);

    // R13 ignored writes
    wr_reg(3'd2, 8'hFF);
    wr_reg(3'd5, 8'hFF);
    wr_reg(3'd6, 8'hFF);
    rd_reg(3'd5, d); chk("R13 lsr", d, 8'h60);
    rd_reg(3'd6, d); chk("R13 msr", d, 8'h00);
    rd_reg(3'd2, d); chk("R13 iir", d, 8'h01);

    // R8 / R10 enable mask and holding-empty cause
    wr_reg(3'd1, 8'hFF);
    rd_reg(3'd1, d); chk("R8 ier width", d, 8'h0F);
    rd_reg(3'd2, d); chk("R10 enable while empty", d, 8'h02);
    rd_reg(3'd2, d); chk("R10 cleared by iir read", d, 8'h01);
    wr_reg(3'd1, 8'h00);

    // R6 modem status
    @(negedge clk); cts = 1;
    @(negedge clk);
    rd_reg(3'd6, d); chk("R6 cts delta", d, 8'h11);
    rd_reg(3'd6, d); chk("R6 delta cleared", d, 8'h10);
    @(negedge clk); dsr = 1; dcd = 1; ri = 1;
    @(negedge clk);
    rd_reg(3'd6, d); chk("R6 ri rise no flag", d, 8'hFA);
    @(negedge clk); ri = 0;
    @(negedge clk);
    rd_reg(3'd6, d); chk("R6 ri trailing", d, 8'hB4);
    @(negedge clk); cts = 0; dsr = 0; dcd = 0;
    @(negedge clk);
    rd_reg(3'd6, d); chk("R6 falls", d, 8'h0B);
    rd_reg(3'd6, d); chk("R6 quiet", d, 8'h00);

    // R7 loopback
    wr_reg(3'd4, 8'h1F);
    chk("R7 outputs held low", {dtr, rts, out1, out2}, 4'b0000);
    rd_reg(3'd6, d); chk("R7 loop routing", d, 8'hFB);
    wr_reg(3'd4, 8'hEF);
    chk("R7 outputs released", {dtr, rts, out1, out2}, 4'b1111);
    rd_reg(3'd4, d); chk("R7 mcr width", d, 8'h0F);
    rd_reg(3'd6, d); chk("R7 leave loop", d, 8'h0F);

    // R11 OUT2 gating
    do_reset();
    wr_reg(3'd1, 8'h01);
    rx_byte(8'h00, 0, 0, 0);
    chk("R11 irq gated", irq, 0);
    rd_reg(3'd2, d); chk("R8 rx cause", d, 8'h04);
    wr_reg(3'd4, 8'h08);
    chk("R11 irq on", irq, 1);

    // R9 / R10 / R11 sweep: cause set x enable mask (bit positions as enable)
    for (int c = 0; c < 16; c++) begin
      for (int e = 0; e < 16; e++) begin
        logic [3:0] eff, c2;
        logic [7:0] first;
        do_reset();
        wr_reg(3'd4, c[3] ? 8'h18 : 8'h08);
        wr_reg(3'd0, 8'h00);
        wr_reg(3'd1, 8'(e));
        if (c[2]) begin
          rx_byte(8'h00, 1, 0, 0);
          rd_reg(3'd0, d);
        end
        if (c[0]) rx_byte(8'h33, 0, 0, 0);
        if (c[1]) tx_take();
        repeat (2) @(negedge clk);
        eff = 4'(c) & 4'(e);
        chk($sformatf("R11 irq c=%0h e=%0h", c, e), irq, (eff != 0));
        first = exp_iir(eff);
        rd_reg(3'd2, d);
        chk($sformatf("R9 iir c=%0h e=%0h", c, e), d, first);
        c2 = (first == 8'h02) ? (4'(c) & 4'b1101) : 4'(c);
        rd_reg(3'd2, d);
        chk($sformatf("R10 iir reread c=%0h e=%0h", c, e), d, exp_iir(c2 & 4'(e)));
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule